// File: doc/BRIEF.md
# Converter status and interrupt flags

This block holds the event flags of a data-converter controller and turns them into one interrupt line. The conversion engine sends single-cycle pulses: ready, end of sampling, end of regular conversion, end of regular sequence, injected end of conversion, injected end of sequence, three watchdog hits and queue overflow. Each pulse sets a sticky flag. An enable register masks the flags, and the masked flags drive a registered interrupt output.

A simple register bus gives software access. Software reads the flags and clears them by writing ones. It writes the interrupt enables and a converter-enable control bit. It also reads the regular result register and the injected result slots.

Reading a result register has a side effect: it acknowledges the matching end-of-conversion flag. A regular result that arrives while the previous one is still unacknowledged raises an overrun flag. An input pin selects whether that newer result replaces the stored data or is dropped.

Top module: `conv_irq_status`

## Requirements
- R1: Each event pulse sets its flag on the next clock edge. The flags read at bus address 0 with these bit positions: ready 0, end of sampling 1, regular end of conversion 2, regular end of sequence 3, overrun 4, injected end of conversion 5, injected end of sequence 6, watchdog hits 7, 8 and 9 (ev_awd bits 0, 1 and 2), queue overflow 10.
- R2: Writing 1 to a bit at address 0 clears that flag. Writing 0 leaves the flag unchanged.
- R3: If an event sets a flag in the same cycle that software writes 1 to clear it, the flag ends up set.
- R4: A read of address 3 returns the regular result in bits DW-1:0 and clears flag bit 2.
- R5: On an injected result (ev_jeoc), ev_jdata is stored in slot ev_jslot. A read of address 4+k returns slot k and clears flag bit 5.
- R6: An overrun sets flag bit 4. This happens when ev_eoc arrives while flag bit 2 is set and is not being cleared in that same cycle. If flag bit 2 is clear, or is cleared in that cycle, ev_eoc does not set flag bit 4.
- R7: On an overrun with keep_old low, the regular data register takes the new result. With keep_old high it keeps the old value. Without an overrun, ev_eoc always stores the new result.
- R8: The ready flag sets on ev_ready only while the control bit at address 2 bit 0 is 1.
- R9: Address 1 holds the interrupt enables, using the same bit positions as the flags. irq is the OR of all flags ANDed with their enables, registered. It is one cycle behind the flags.
- R10: After reset, all flags, enables, the control bit, the data registers and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ready | input | 1 | Converter can accept requests |
| ev_eosmp | input | 1 | End of sampling pulse |
| ev_eoc | input | 1 | Regular conversion done pulse |
| ev_data | input | DW | Regular result, valid with ev_eoc |
| ev_eos | input | 1 | Regular sequence done pulse |
| ev_jeoc | input | 1 | Injected conversion done pulse |
| ev_jslot | input | JW | Injected slot index, valid with ev_jeoc |
| ev_jdata | input | DW | Injected result, valid with ev_jeoc |
| ev_jeos | input | 1 | Injected sequence done pulse |
| ev_awd | input | 3 | Watchdog hit pulses |
| ev_qovf | input | 1 | Queue overflow pulse |
| keep_old | input | 1 | On overrun: 1 keeps the old data, 0 overwrites it |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | BW | Write data |
| bus_rdata | output | BW | Read data, combinational during a read |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest cases to reach are the ones where a hardware event and a bus access land in the same clock edge. Examples are a clear-by-write racing a new event, and a data read racing a new result. The stimulus for these drives the event pins and the bus signals together in one cycle.

Overrun has its own ordered steps. First a result arrives. A second result then arrives before any read. This is done once with keep_old low and once with it high. The stored data is read back to tell overwrite from keep. A read placed between the two results shows that no overrun is raised.

// File: rtl/conv_irq_status.sv
module conv_irq_status #(
  parameter int DW = 16,
  parameter int NJ = 4,
  parameter int AW = 4,
  parameter int BW = 32,
  localparam int JW = (NJ > 1) ? $clog2(NJ) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ready,
  input  logic          ev_eosmp,
  input  logic          ev_eoc,
  input  logic [DW-1:0] ev_data,
  input  logic          ev_eos,
  input  logic          ev_jeoc,
  input  logic [JW-1:0] ev_jslot,
  input  logic [DW-1:0] ev_jdata,
  input  logic          ev_jeos,
  input  logic [2:0]    ev_awd,
  input  logic          ev_qovf,
  input  logic          keep_old,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NF = 11;
  localparam logic [AW-1:0] A_FLAG = AW'(0);
  localparam logic [AW-1:0] A_IEN  = AW'(1);
  localparam logic [AW-1:0] A_CTL  = AW'(2);
  localparam logic [AW-1:0] A_DR   = AW'(3);
  localparam logic [AW-1:0] A_JB   = AW'(4);
  localparam logic [AW-1:0] A_JE   = AW'(4 + NJ);

  logic [NF-1:0] flag_q, ien_q, ev_set, w1c;
  logic          ctl_en_q;
  logic [DW-1:0] dr_q;
  logic [DW-1:0] jdr_q [NJ];

  wire rd     = bus_sel & ~bus_wr;
  wire wr     = bus_sel & bus_wr;
  wire rd_dr  = rd && (bus_addr == A_DR);
  wire rd_jdr = rd && (bus_addr >= A_JB) && (bus_addr < A_JE);
  wire wr_flg = wr && (bus_addr == A_FLAG);
  wire [JW-1:0] jsel = JW'(bus_addr - A_JB);

  wire eoc_clr = (wr_flg & bus_wdata[2]) | rd_dr;
  wire ovr     = ev_eoc & flag_q[2] & ~eoc_clr;

  assign ev_set = {ev_qovf, ev_awd, ev_jeos, ev_jeoc, ovr,
                   ev_eos, ev_eoc, ev_eosmp, ev_ready & ctl_en_q};

  always_comb begin
    w1c = wr_flg ? bus_wdata[NF-1:0] : '0;
    w1c[2] = w1c[2] | rd_dr;
    w1c[5] = w1c[5] | rd_jdr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= '0;
      ien_q    <= '0;
      ctl_en_q <= 1'b0;
      irq      <= 1'b0;
    end else begin
      flag_q <= ev_set | (flag_q & ~w1c);
      irq    <= |(flag_q & ien_q);
      if (wr && bus_addr == A_IEN) ien_q <= bus_wdata[NF-1:0];
      if (wr && bus_addr == A_CTL) ctl_en_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      dr_q <= '0;
    else if (ev_eoc && !(ovr && keep_old)) dr_q <= ev_data;
  end

  for (genvar k = 0; k < NJ; k++) begin : g_jslot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              jdr_q[k] <= '0;
      else if (ev_jeoc && ev_jslot == JW'(k))  jdr_q[k] <= ev_jdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (bus_addr == A_FLAG)     bus_rdata[NF-1:0] = flag_q;
      else if (bus_addr == A_IEN) bus_rdata[NF-1:0] = ien_q;
      else if (bus_addr == A_CTL) bus_rdata[0]      = ctl_en_q;
      else if (rd_dr)             bus_rdata[DW-1:0] = dr_q;
      else if (rd_jdr)            bus_rdata[DW-1:0] = jdr_q[jsel];
    end
  end
endmodule

module conv_irq_status_chk #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int BW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [10:0]   flag_q,
  input logic [10:0]   ien_q,
  input logic          ctl_en_q,
  input logic [DW-1:0] dr_q,
  input logic          irq,
  input logic          ev_ready,
  input logic          ev_eosmp,
  input logic          ev_eoc,
  input logic          ev_eos,
  input logic          ev_jeoc,
  input logic          ev_jeos,
  input logic [2:0]    ev_awd,
  input logic          ev_qovf,
  input logic          keep_old,
  input logic          bus_sel,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] bus_wdata
);
  wire no_ev = !(ev_ready | ev_eosmp | ev_eoc | ev_eos | ev_jeoc | ev_jeos | (|ev_awd) | ev_qovf);

  AST_EOC_SETS: assert property (@(posedge clk) disable iff (!rst_n) ev_eoc |=> flag_q[2]); // R1
  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 0 && bus_wdata[10:0] == 11'd0 && no_ev) |=> $stable(flag_q)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eos && bus_sel && bus_wr && bus_addr == 0 && bus_wdata[3]) |=> flag_q[3]); // R3
  AST_DR_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == 3 && !ev_eoc) |=> !flag_q[2]); // R4
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eoc && flag_q[2] && !bus_sel) |=> flag_q[4]); // R6
  AST_KEEP_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_eoc && flag_q[2] && keep_old && !bus_sel) |=> $stable(dr_q)); // R7
  AST_RDY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en_q && !flag_q[0]) |=> !flag_q[0]); // R8
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ien_q)) |=> irq); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flag_q & ien_q)) |=> !irq); // R9
endmodule

bind conv_irq_status conv_irq_status_chk #(.DW(DW), .AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .ien_q(ien_q), .ctl_en_q(ctl_en_q),
  .dr_q(dr_q), .irq(irq), .ev_ready(ev_ready), .ev_eosmp(ev_eosmp), .ev_eoc(ev_eoc),
  .ev_eos(ev_eos), .ev_jeoc(ev_jeoc), .ev_jeos(ev_jeos), .ev_awd(ev_awd),
  .ev_qovf(ev_qovf), .keep_old(keep_old), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/sim_conv_irq_status.sv
`timescale 1ns/1ps
module sim_conv_irq_status;
  logic clk = 0, rst_n = 0;
  logic ev_ready = 0, ev_eosmp = 0, ev_eoc = 0, ev_eos = 0, ev_jeoc = 0, ev_jeos = 0, ev_qovf = 0;
  logic [2:0] ev_awd = 0;
  logic [15:0] ev_data = 0, ev_jdata = 0;
  logic [1:0] ev_jslot = 0;
  logic keep_old = 0, bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  conv_irq_status u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 0;
  endtask

  // m: 0 ready,1 eosmp,2 eoc,3 eos,4 jeoc,5 jeos,6..8 awd,9 qovf
  task automatic fire(input logic [9:0] m, input logic [15:0] d, input logic [1:0] s);
    {ev_qovf, ev_awd, ev_jeos, ev_jeoc, ev_eos, ev_eoc, ev_eosmp, ev_ready} = m;
    ev_data = d; ev_jdata = d; ev_jslot = s;
    @(posedge clk); @(negedge clk);
    {ev_qovf, ev_awd, ev_jeos, ev_jeoc, ev_eos, ev_eoc, ev_eosmp, ev_ready} = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, v); chk("R10 flags", v, 0);
    rd(3, v); chk("R10 data", v, 0);
    rd(2, v); chk("R10 ctl", v, 0);
    chk("R10 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_ready_gate();
    logic [31:0] v;
    fire(10'd1, 0, 0);
    rd(0, v); chk("R8 ready gated off", v, 0);
    wr(2, 1);
    fire(10'd1, 0, 0);
    rd(0, v); chk("R8 ready with enable", v, 32'h1);
    wr(0, 32'h1);
  endtask

  task automatic t_bits();
    logic [31:0] v;
    for (int i = 1; i < 10; i++) begin
      int p = (i < 4) ? i : i + 1;
      fire(10'(1 << i), 16'h0005, 0);
      rd(0, v); chk("R1 flag position", v, 32'(1 << p));
      wr(0, 32'(1 << p));
      rd(0, v); chk("R2 write one clears", v, 0);
    end
  endtask

  task automatic t_zero_write();
    logic [31:0] v;
    fire(10'h008, 0, 0);
    wr(0, 0);
    rd(0, v); chk("R2 zero write keeps", v, 32'h8);
    wr(0, 32'h8);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 32'h8; ev_eos = 1;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wdata = 0; ev_eos = 0;
    rd(0, v); chk("R3 set beats clear", v, 32'h8);
    wr(0, 32'h8);
  endtask

  task automatic t_eoc_read();
    logic [31:0] v;
    fire(10'h004, 16'h1234, 0);
    rd(0, v); chk("R4 eoc set", v, 32'h4);
    rd(3, v); chk("R4 data value", v, 32'h1234);
    rd(0, v); chk("R4 read clears eoc", v, 0);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    keep_old = 0;
    fire(10'h004, 16'h0011, 0);
    fire(10'h004, 16'h0022, 0);
    rd(0, v); chk("R6 overrun raised", v, 32'h14);
    rd(3, v); chk("R7 overwrite", v, 32'h0022);
    wr(0, 32'h7FF);
    keep_old = 1;
    fire(10'h004, 16'h0033, 0);
    fire(10'h004, 16'h0044, 0);
    rd(0, v); chk("R6 overrun keep mode", v, 32'h14);
    rd(3, v); chk("R7 keep old", v, 32'h0033);
    wr(0, 32'h7FF);
    fire(10'h004, 16'h0055, 0);
    rd(3, v); chk("R7 no overrun stores", v, 32'h0055);
    fire(10'h004, 16'h0066, 0);
    rd(0, v); chk("R6 no overrun after read", v, 32'h4);
    wr(0, 32'h7FF);
    keep_old = 0;
  endtask

  task automatic t_injected();
    logic [31:0] v;
    fire(10'h010, 16'hABCD, 2);
    fire(10'h010, 16'h1357, 1);
    rd(0, v); chk("R5 jeoc set", v, 32'h20);
    rd(6, v); chk("R5 slot 2", v, 32'hABCD);
    rd(0, v); chk("R5 read clears jeoc", v, 0);
    rd(5, v); chk("R5 slot 1", v, 32'h1357);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(1, 32'h8);
    rd(1, v); chk("R9 enable readback", v, 32'h8);
    fire(10'h002, 0, 0);
    @(negedge clk);
    chk("R9 masked flag no irq", {31'd0, irq}, 0);
    wr(0, 32'h2);
    fire(10'h008, 0, 0);
    chk("R9 irq lags flag", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R9 irq raised", {31'd0, irq}, 1);
    wr(0, 32'h8);
    chk("R9 irq still one", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R9 irq drops", {31'd0, irq}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ready_gate();
    t_bits();
    t_zero_write();
    t_set_wins();
    t_eoc_read();
    t_overrun();
    t_injected();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule